// File: doc/BRIEF.md
# Fixed-Timing Parallel Bus Cycle Master

This block is a bus master for an 8-bit parallel peripheral bus with separate address and data lines. A host presents a single request carrying an address, write data, a direction flag and an address-space flag (memory or I/O). The block turns that request into one timed bus cycle. It drives the address lines and exactly one of four active-low strobes: memory read, memory write, I/O read or I/O write. On writes it also drives the bidirectional data bus.

Cycle timing comes only from the block's clock. The addressed device returns no ready or acknowledge signal, so the master alone sets the cycle length. A memory cycle takes four clocks and an I/O cycle takes five, for reads and writes alike. Read data is captured at the end of the last cycle clock. A one-clock done pulse then returns it to the host. While a cycle runs, `busy_o` is high and further requests are ignored.

Top module: `isa_cycle_master`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, all four strobes are high (inactive), and the block does not drive the data bus.
- R2: A memory cycle (`req_io_i`=0) accepted at a clock edge holds `busy_o` high for exactly 4 clocks. Its strobe is low in clocks 2, 3 and 4 and high in clock 1.
- R3: An I/O cycle (`req_io_i`=1) holds `busy_o` high for exactly 5 clocks. Its strobe is low in clocks 2 to 5 and high in clock 1.
- R4: The strobe used is chosen from the two flags: `bus_memr_no` for io=0/we=0, `bus_memw_no` for io=0/we=1, `bus_ior_no` for io=1/we=0, and `bus_iow_no` for io=1/we=1. At most one strobe is low at any time.
- R5: `bus_addr_o` shows the accepted address from clock 1 of the cycle. It stays unchanged through the last clock.
- R6: The block drives the latched write data onto `bus_data_io` only while a write strobe is low. At every other time it leaves the data bus undriven.
- R7: A read cycle samples `bus_data_io` at the clock edge that ends its last clock. The sampled value appears on `rdata_o` in the clock after the cycle, while `done_o` is high.
- R8: A request is accepted only when `busy_o` is low. A request held high during a cycle changes neither the address, the strobes nor the cycle length, and it does not start another cycle.
- R9: `done_o` is high for exactly one clock after each cycle, writes included. `rdata_o` holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when `busy_o` is low |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | 20 | Request address |
| req_wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Last captured read data |
| bus_addr_o | output | 20 | Bus address lines |
| bus_memr_no | output | 1 | Memory read strobe, active low |
| bus_memw_no | output | 1 | Memory write strobe, active low |
| bus_ior_no | output | 1 | I/O read strobe, active low |
| bus_iow_no | output | 1 | I/O write strobe, active low |
| bus_data_io | inout | 8 | Bidirectional data bus |

## Verification
The assertions assume that the device drives the data bus only while a read strobe is low. They also assume that the host's request fields are meaningful only in a clock where `busy_o` is low. The bench device model drives data only under a read strobe. Its value changes on every strobe clock, so a capture on the wrong edge gives a different byte. The host side either drops the request after acceptance, or deliberately keeps it high with altered fields during the cycle and drops it before the done clock, so that the hold-off property is checked without starting an unplanned cycle.

// File: rtl/isa_cycle_pkg.sv
package isa_cycle_pkg;
  typedef enum logic [1:0] {
    K_MEM_RD = 2'b00,
    K_MEM_WR = 2'b01,
    K_IO_RD  = 2'b10,
    K_IO_WR  = 2'b11
  } cyc_kind_e;

  function automatic cyc_kind_e kind_of(input logic io, input logic we);
    return cyc_kind_e'({io, we});
  endfunction
endpackage

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_cycle_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int MEM_CLKS = 4,
  parameter int IO_CLKS  = 5,
  parameter int CW       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          io_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          active_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output cyc_kind_e     kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o
);
  localparam logic [CW-1:0] MemLast = CW'(MEM_CLKS);
  localparam logic [CW-1:0] IoLast  = CW'(IO_CLKS);

  logic          active_q, we_q, io_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept, last;

  assign accept = req_i && !active_q;
  assign last   = active_q && (cnt_q == (io_q ? IoLast : MemLast));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      we_q     <= 1'b0;
      io_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(1);
        we_q     <= we_i;
        io_q     <= io_i;
        addr_q   <= addr_i;
        wdata_q  <= wdata_i;
      end else if (last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign last_o   = last;
  assign kind_o   = kind_of(io_q, we_q);
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign done_o   = done_q;

  // R5: address frozen while the cycle runs
  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last) |=> $stable(addr_q));
  // R8: no restart inside a cycle
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last && req_i) |=> (cnt_q != CW'(1)));
  // R7, R9: single done after the last clock
  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> done_q);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
  import isa_cycle_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [CW-1:0] cnt_i,
  input  cyc_kind_e     kind_i,
  output logic          memr_no,
  output logic          memw_no,
  output logic          ior_no,
  output logic          iow_no,
  output logic          wr_on_o
);
  localparam logic [CW-1:0] FirstStrobeClk = CW'(2);

  logic       strb_on;
  logic [3:0] sel;

  assign strb_on = active_i && (cnt_i >= FirstStrobeClk);

  always_comb begin
    sel = '0;
    if (strb_on) sel[kind_i] = 1'b1;
  end

  assign memr_no = ~sel[K_MEM_RD];
  assign memw_no = ~sel[K_MEM_WR];
  assign ior_no  = ~sel[K_IO_RD];
  assign iow_no  = ~sel[K_IO_WR];
  assign wr_on_o = sel[K_MEM_WR] | sel[K_IO_WR];

  // R4: one strobe at most
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~memr_no, ~memw_no, ~ior_no, ~iow_no}));
  // R2, R3: strobe off in clock 1
  a_r2_r3_no_strobe_clk1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i == CW'(1)) |-> (&{memr_no, memw_no, ior_no, iow_no}));
endmodule

// File: rtl/isa_data_path.sv
module isa_data_path #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drive_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture_i,
  output logic [DW-1:0] rdata_o,
  inout  wire  [DW-1:0] bus_data_io
);
  logic [DW-1:0] rdata_q;

  assign bus_data_io = drive_i ? wdata_i : {DW{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= bus_data_io;
  end

  assign rdata_o = rdata_q;

  // R9: read data only moves on a capture
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_q));
endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
  import isa_cycle_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int MEM_CLKS = 4,
  parameter int IO_CLKS  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_io_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_memr_no,
  output logic          bus_memw_no,
  output logic          bus_ior_no,
  output logic          bus_iow_no,
  inout  wire  [DW-1:0] bus_data_io
);
  localparam int MaxClks = (IO_CLKS > MEM_CLKS) ? IO_CLKS : MEM_CLKS;
  localparam int CW      = $clog2(MaxClks + 1);

  logic          active, last, wr_on, capture;
  logic [CW-1:0] cnt;
  cyc_kind_e     kind;
  logic [DW-1:0] wdata;

  isa_cycle_seq #(
    .AW(AW), .DW(DW), .MEM_CLKS(MEM_CLKS), .IO_CLKS(IO_CLKS), .CW(CW)
  ) seq_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (req_we_i),
    .io_i    (req_io_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .active_o(active),
    .cnt_o   (cnt),
    .last_o  (last),
    .kind_o  (kind),
    .addr_o  (bus_addr_o),
    .wdata_o (wdata),
    .done_o  (done_o)
  );

  isa_strobe_gen #(.CW(CW)) strobe_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .cnt_i   (cnt),
    .kind_i  (kind),
    .memr_no (bus_memr_no),
    .memw_no (bus_memw_no),
    .ior_no  (bus_ior_no),
    .iow_no  (bus_iow_no),
    .wr_on_o (wr_on)
  );

  assign capture = last && (kind == K_MEM_RD || kind == K_IO_RD);

  isa_data_path #(.DW(DW)) data_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_i    (wr_on),
    .wdata_i    (wdata),
    .capture_i  (capture),
    .rdata_o    (rdata_o),
    .bus_data_io(bus_data_io)
  );

  assign busy_o = active;

  // R2: memory cycle ends after its 4th clock
  a_r2_mem_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt == CW'(MEM_CLKS) && !bus_memr_no) |=> !busy_o);
  // R3: I/O cycle runs past the memory length
  a_r3_io_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt == CW'(MEM_CLKS) && !bus_ior_no) |=> busy_o);
  // R6: write driver only under a write strobe
  a_r6_drive_under_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_on |-> (!bus_memw_no || !bus_iow_no));
  // R1, R9: done never overlaps a running strobe
  a_r9_done_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&{bus_memr_no, bus_memw_no, bus_ior_no, bus_iow_no}));
endmodule

// File: tb/isa_cycle_master_tb_top.sv
module isa_cycle_master_tb_top;
  localparam int ClkPeriod = 10;
  localparam int AW = 20;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_we = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;
  logic          memr_n, memw_n, ior_n, iow_n;
  wire  [DW-1:0] bus_data;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] last_rd = '0;

  always #(ClkPeriod/2) clk = ~clk;

  isa_cycle_master dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .req_we_i   (req_we),
    .req_io_i   (req_io),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .busy_o     (busy),
    .done_o     (done),
    .rdata_o    (rdata),
    .bus_addr_o (bus_addr),
    .bus_memr_no(memr_n),
    .bus_memw_no(memw_n),
    .bus_ior_no (ior_n),
    .bus_iow_no (iow_n),
    .bus_data_io(bus_data)
  );

  // device model: value moves on every strobe clock
  logic [2:0] dev_cnt = '0;
  logic       dev_rd;
  assign dev_rd = !memr_n || !ior_n;
  always @(posedge clk) dev_cnt <= dev_rd ? dev_cnt + 3'd1 : 3'd0;

  function automatic logic [DW-1:0] dev_base(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h5, a[19:16]};
  endfunction
  assign bus_data = dev_rd ? (dev_base(bus_addr) ^ {5'd0, dev_cnt}) : 8'hzz;

  function automatic int cyc_len(input logic io);
    return io ? 5 : 4;
  endfunction

  // {memr, memw, ior, iow} active-low, expected
  function automatic logic [3:0] exp_strb(input logic on, input logic io, input logic we);
    logic [3:0] v;
    v = 4'b1111;
    if (on) v[3 - {io, we}] = 1'b0;
    return v;
  endfunction

  task automatic chk(input logic ok, input string req_tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic run_cycle(input logic we, input logic io, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic hold);
    int n;
    logic [3:0] s;
    n = cyc_len(io);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; req_we = we; req_io = io; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (hold) begin
      req_addr = ~a; req_we = ~we; req_io = ~io; req_wdata = ~wd;
    end else req = 1'b0;
    for (int k = 1; k <= n; k++) begin
      s = {memr_n, memw_n, ior_n, iow_n};
      chk(busy === 1'b1, io ? "R3 busy" : "R2 busy", 32'(busy), 1);
      chk(s === exp_strb(k >= 2, io, we), io ? "R3/R4 strobe" : "R2/R4 strobe",
          32'(s), 32'(exp_strb(k >= 2, io, we)));
      chk(bus_addr === a, hold ? "R8 addr" : "R5 addr", 32'(bus_addr), 32'(a));
      if (we) begin
        if (k >= 2) chk(bus_data === wd, "R6 drive", 32'(bus_data), 32'(wd));
        else        chk(bus_data !== wd, "R6 idle clk1", 32'(bus_data), 32'(~wd));
      end
      chk(done === 1'b0, "R9 early done", 32'(done), 0);
      @(negedge clk);
    end
    req = 1'b0;
    s = {memr_n, memw_n, ior_n, iow_n};
    chk(done === 1'b1, "R9 done", 32'(done), 1);
    chk(busy === 1'b0, io ? "R3 length" : "R2 length", 32'(busy), 0);
    chk(s === 4'b1111, "R4 strobes off", 32'(s), 32'hf);
    if (we) begin
      chk(bus_data !== wd, "R6 released", 32'(bus_data), 32'(~wd));
      chk(rdata === last_rd, "R9 rdata hold", 32'(rdata), 32'(last_rd));
    end else begin
      last_rd = dev_base(a) ^ DW'(n - 2);
      chk(rdata === last_rd, "R7 capture", 32'(rdata), 32'(last_rd));
    end
    @(negedge clk);
    chk(done === 1'b0, "R9 pulse width", 32'(done), 0);
    chk(busy === 1'b0, "R8 no extra cycle", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1ced));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(done === 1'b0, "R1 done", 32'(done), 0);
    chk({memr_n, memw_n, ior_n, iow_n} === 4'b1111, "R1 strobes",
        32'({memr_n, memw_n, ior_n, iow_n}), 32'hf);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 idle after reset", 32'(busy), 0);
    // directed: each kind, with and without hold-off
    run_cycle(1'b0, 1'b0, 20'h12345, 8'h00, 1'b0);
    run_cycle(1'b0, 1'b1, 20'h003f8, 8'h00, 1'b0);
    run_cycle(1'b1, 1'b0, 20'hfffff, 8'ha5, 1'b0);
    run_cycle(1'b1, 1'b1, 20'h00000, 8'h3c, 1'b0);
    run_cycle(1'b0, 1'b1, 20'h0abcd, 8'h00, 1'b1);
    run_cycle(1'b1, 1'b0, 20'h54321, 8'h81, 1'b1);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_cycle(r[0], r[1], AW'($urandom), DW'($urandom) | 8'h01, r[2] & r[3]);
    end
    summary();
    $finish;
  end
endmodule